// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits between a CPU's physical address stream and the targets behind a host bridge. Each target window has three software-programmed registers: a low-decode field, a high-decode field and a remap field. The window base and limit are derived from these fields at 2 MB granularity. A lookup presents a CPU address. One cycle later the block returns a one-hot hit vector and the address translated into the target's space. Alongside the programmable windows there is one fixed-size internal window that covers the bridge's own register space.

Programmable windows are clipped around two hard-wired reserved holes. A window whose begin falls inside a hole starts after that hole. A window whose end falls inside a hole, or whose range spans a hole, stops at the start of that hole. Overlapping windows are resolved by index, and the lowest index wins. The window chosen as the I/O window passes only a 16-bit port address to its target.

Software reaches the registers through a plain write/read port. A write to a low-decode field also reloads that window's remap field. Read data is registered.

Top module: `awd_decoder`

## Requirements
- R1: A write to window i's low field (register offset 4*i+0) stores bits [14:0] of the write data and loads window i's remap field (offset 4*i+2) with bits [10:0] of the same data. A read returns the stored, zero-extended value on reg_rdata in the cycle after reg_rd.
- R2: The high field (offset 4*i+1) keeps write data bits [6:0]. A direct write to the remap field keeps bits [10:0].
- R3: A window's begin is low[10:0] shifted left by 21. Its end is begin + ((high + 1 - low[6:0]) << 21). An address hits when begin <= addr < end.
- R4: A window with low[6:0] > high produces no hit.
- R5: For a programmable window, xlat_addr = lk_addr - begin + (remap << 21), taken modulo 2^32 with the unclipped begin.
- R6: The internal window (hit bit NUM_WIN, base register at offset 4*NUM_WIN, 15 bits kept) spans 4096 bytes from base[10:0] << 21 and is never clipped. Its xlat_addr is the offset of lk_addr from its base.
- R7: Window ranges are clipped against the holes [0x1E000000, 0x1F100000) and [0x1FC00000, 0x1FD00000). The rules are applied in this order: an end inside a hole moves down to the hole start; a begin inside a hole moves up to the hole end; a range spanning a hole ends at that hole's start. No programmable window hits inside a hole.
- R8: hit_vec is one-hot or zero. Bit i is window i, and the lowest set index among the raw hits wins. On a miss, xlat_addr equals lk_addr.
- R9: For window IO_IDX (default 0), xlat_addr keeps only bits [15:0] of the translated address, and the upper bits are zero.
- R10: After reset every programmable window has low = 0x7F, high = 0 and remap = 0x7F, so all are disabled. The internal base is IBASE_RST (default 0xDF, base 0x1BE00000). hit_valid and hit_vec are 0.
- R11: hit_valid, hit_vec and xlat_addr are registered one cycle after lk_valid. A register write is used by lookups sampled in the following cycle. A lookup in the same cycle as the write sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW (5) | Register offset: window index in the upper bits, field in bits [1:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | CPU physical address to decode |
| hit_valid | output | 1 | Lookup result valid |
| hit_vec | output | NUM_WIN+1 (5) | One-hot window hit, with the internal window at the top bit |
| xlat_addr | output | 32 | Translated address |

## Verification
A register write and a lookup can fall in the same clock edge. The bench provokes this by asserting reg_wr, which disables a window, together with lk_valid for an address inside that window. That result must still show the hit from the old settings, and an identical lookup one cycle later must miss. The second concurrent case is priority: two windows cover the same address in one lookup. The bench judges it by requiring the lower index in hit_vec and that window's translation, and the checker enforces that hit_vec is one-hot on every result.

// File: rtl/awd_pkg.sv
package awd_pkg;

  localparam int ADDR_W = 32;
  localparam int EXT_W  = ADDR_W + 1;

  // reserved holes, [start, end)
  localparam logic [EXT_W-1:0] HOLE0_LO = 33'h01E000000;
  localparam logic [EXT_W-1:0] HOLE0_HI = 33'h01F100000;
  localparam logic [EXT_W-1:0] HOLE1_LO = 33'h01FC00000;
  localparam logic [EXT_W-1:0] HOLE1_HI = 33'h01FD00000;

  typedef enum logic [1:0] {
    FLD_LOW   = 2'd0,
    FLD_HIGH  = 2'd1,
    FLD_REMAP = 2'd2,
    FLD_NONE  = 2'd3
  } fld_e;

  // Ordered clipping of a range against both holes.
  function automatic void clip_range(input  logic [EXT_W-1:0] b_i,
                                     input  logic [EXT_W-1:0] e_i,
                                     output logic [EXT_W-1:0] b_o,
                                     output logic [EXT_W-1:0] e_o);
    logic [EXT_W-1:0] b, e;
    b = b_i;
    e = e_i;
    if (e >= HOLE0_LO && e < HOLE0_HI) e = HOLE0_LO;
    if (b >= HOLE0_LO && b < HOLE0_HI) b = HOLE0_HI;
    if (e >= HOLE1_LO && e < HOLE1_HI) e = HOLE1_LO;
    if (b >= HOLE1_LO && b < HOLE1_HI) b = HOLE1_HI;
    if (e >= HOLE0_HI && b < HOLE0_LO) e = HOLE0_LO;
    if (e >= HOLE1_HI && b < HOLE1_LO) e = HOLE1_LO;
    b_o = b;
    e_o = e;
  endfunction

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int LOW_W     = 15,
  parameter int HIGH_W    = 7,
  parameter int REMAP_W   = 11,
  parameter int REG_AW    = 5,
  parameter logic [LOW_W-1:0] IBASE_RST = 15'h00DF
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              reg_wr,
  input  logic                              reg_rd,
  input  logic [REG_AW-1:0]                 reg_addr,
  input  logic [ADDR_W-1:0]                 reg_wdata,
  output logic [ADDR_W-1:0]                 reg_rdata,
  output logic [NUM_WIN-1:0][REMAP_W-1:0]   low_base,
  output logic [NUM_WIN-1:0][HIGH_W-1:0]    high_q,
  output logic [NUM_WIN-1:0][REMAP_W-1:0]   remap_q,
  output logic [REMAP_W-1:0]                ibase_base
);

  localparam int IDX_W = REG_AW - 2;
  localparam logic [HIGH_W-1:0] LOW_RST = {HIGH_W{1'b1}};

  logic [NUM_WIN-1:0][LOW_W-1:0] low_q;
  logic [LOW_W-1:0]              ibase_q;
  logic [IDX_W-1:0]              idx;
  fld_e                          fld;

  assign idx = reg_addr[REG_AW-1:2];
  assign fld = fld_e'(reg_addr[1:0]);

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic sel;
    assign sel = reg_wr && (idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        low_q[i]   <= LOW_W'(LOW_RST);
        high_q[i]  <= '0;
        remap_q[i] <= REMAP_W'(LOW_RST);
      end else if (sel) begin
        case (fld)
          FLD_LOW: begin
            low_q[i]   <= reg_wdata[LOW_W-1:0];
            remap_q[i] <= reg_wdata[REMAP_W-1:0];
          end
          FLD_HIGH:  high_q[i]  <= reg_wdata[HIGH_W-1:0];
          FLD_REMAP: remap_q[i] <= reg_wdata[REMAP_W-1:0];
          default: ;
        endcase
      end
    end

    assign low_base[i] = low_q[i][REMAP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      ibase_q <= IBASE_RST;
    else if (reg_wr && idx == IDX_W'(NUM_WIN) && fld == FLD_LOW)
      ibase_q <= reg_wdata[LOW_W-1:0];
  end

  assign ibase_base = ibase_q[REMAP_W-1:0];

  logic [ADDR_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (idx == IDX_W'(NUM_WIN)) begin
      if (fld == FLD_LOW) rd_mux = ADDR_W'(ibase_q);
    end else begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (idx == IDX_W'(i)) begin
          case (fld)
            FLD_LOW:   rd_mux = ADDR_W'(low_q[i]);
            FLD_HIGH:  rd_mux = ADDR_W'(high_q[i]);
            FLD_REMAP: rd_mux = ADDR_W'(remap_q[i]);
            default:   rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/awd_window.sv
module awd_window
  import awd_pkg::*;
#(
  parameter int HIGH_W  = 7,
  parameter int REMAP_W = 11,
  parameter int GRAN_SH = 21,
  parameter int IO_KEEP = 16,
  parameter bit IS_IO   = 1'b0
) (
  input  logic [REMAP_W-1:0] low_base,
  input  logic [HIGH_W-1:0]  high,
  input  logic [REMAP_W-1:0] remap,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [ADDR_W-1:0]  xlat
);

  logic [ADDR_W-1:0] base, rbase, moved;
  logic [HIGH_W:0]   units;
  logic [EXT_W-1:0]  len, beg_raw, end_raw, beg_c, end_c, addr_x;
  logic              enable;

  assign enable  = low_base[HIGH_W-1:0] <= high;
  assign base    = ADDR_W'(low_base) << GRAN_SH;
  assign rbase   = ADDR_W'(remap) << GRAN_SH;
  assign units   = {1'b0, high} + (HIGH_W+1)'(1) - {1'b0, low_base[HIGH_W-1:0]};
  assign len     = EXT_W'(units) << GRAN_SH;
  assign beg_raw = {1'b0, base};
  assign end_raw = beg_raw + len;
  assign addr_x  = {1'b0, addr};

  always_comb begin
    clip_range(beg_raw, end_raw, beg_c, end_c);
  end

  assign hit   = enable && (addr_x >= beg_c) && (addr_x < end_c);
  assign moved = addr - base + rbase;

  if (IS_IO) begin : g_io
    assign xlat = {{(ADDR_W-IO_KEEP){1'b0}}, moved[IO_KEEP-1:0]};
  end else begin : g_mem
    assign xlat = moved;
  end

endmodule

// File: rtl/awd_iwin.sv
module awd_iwin
  import awd_pkg::*;
#(
  parameter int REMAP_W    = 11,
  parameter int GRAN_SH    = 21,
  parameter int IWIN_BYTES = 4096
) (
  input  logic [REMAP_W-1:0] ibase,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [ADDR_W-1:0]  xlat
);

  logic [ADDR_W-1:0] base;
  logic [EXT_W-1:0]  lim;

  assign base = ADDR_W'(ibase) << GRAN_SH;
  assign lim  = {1'b0, base} + EXT_W'(IWIN_BYTES);
  assign hit  = (addr >= base) && ({1'b0, addr} < lim);
  assign xlat = addr - base;

endmodule

// File: rtl/awd_prio.sv
module awd_prio
  import awd_pkg::*;
#(
  parameter int N = 5
) (
  input  logic [N-1:0]              hits,
  input  logic [N-1:0][ADDR_W-1:0]  xlats,
  input  logic [ADDR_W-1:0]         addr,
  output logic [N-1:0]              sel,
  output logic [ADDR_W-1:0]         xlat
);

  always_comb begin
    sel  = '0;
    xlat = addr;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
        xlat   = xlats[i];
      end
    end
  end

endmodule

// File: rtl/awd_decoder.sv
module awd_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN    = 4,
  parameter int IO_IDX     = 0,
  parameter int LOW_W      = 15,
  parameter int HIGH_W     = 7,
  parameter int REMAP_W    = 11,
  parameter int GRAN_SH    = 21,
  parameter int IO_KEEP    = 16,
  parameter int IWIN_BYTES = 4096,
  parameter logic [LOW_W-1:0] IBASE_RST = 15'h00DF,
  localparam int NSLOT     = NUM_WIN + 1,
  localparam int REG_AW    = $clog2(NSLOT) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              hit_valid,
  output logic [NSLOT-1:0]  hit_vec,
  output logic [ADDR_W-1:0] xlat_addr
);

  logic [NUM_WIN-1:0][REMAP_W-1:0] low_base;
  logic [NUM_WIN-1:0][HIGH_W-1:0]  high_q;
  logic [NUM_WIN-1:0][REMAP_W-1:0] remap_q;
  logic [REMAP_W-1:0]              ibase_base;
  logic [NSLOT-1:0]                raw_hit;
  logic [NSLOT-1:0][ADDR_W-1:0]    raw_xlat;
  logic [NSLOT-1:0]                sel;
  logic [ADDR_W-1:0]               sel_xlat;

  awd_regfile #(
    .NUM_WIN(NUM_WIN), .LOW_W(LOW_W), .HIGH_W(HIGH_W), .REMAP_W(REMAP_W),
    .REG_AW(REG_AW), .IBASE_RST(IBASE_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .low_base(low_base), .high_q(high_q), .remap_q(remap_q),
    .ibase_base(ibase_base)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    awd_window #(
      .HIGH_W(HIGH_W), .REMAP_W(REMAP_W), .GRAN_SH(GRAN_SH),
      .IO_KEEP(IO_KEEP), .IS_IO(i == IO_IDX)
    ) u_win (
      .low_base(low_base[i]), .high(high_q[i]), .remap(remap_q[i]),
      .addr(lk_addr), .hit(raw_hit[i]), .xlat(raw_xlat[i])
    );
  end

  awd_iwin #(
    .REMAP_W(REMAP_W), .GRAN_SH(GRAN_SH), .IWIN_BYTES(IWIN_BYTES)
  ) u_iwin (
    .ibase(ibase_base), .addr(lk_addr),
    .hit(raw_hit[NUM_WIN]), .xlat(raw_xlat[NUM_WIN])
  );

  awd_prio #(.N(NSLOT)) u_prio (
    .hits(raw_hit), .xlats(raw_xlat), .addr(lk_addr),
    .sel(sel), .xlat(sel_xlat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid <= 1'b0;
      hit_vec   <= '0;
      xlat_addr <= '0;
    end else begin
      hit_valid <= lk_valid;
      hit_vec   <= lk_valid ? sel : '0;
      if (lk_valid) xlat_addr <= sel_xlat;
    end
  end

endmodule

// File: rtl/awd_checker.sv
module awd_checker
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int IO_IDX  = 0,
  parameter int IO_KEEP = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_valid,
  input logic [ADDR_W-1:0]  lk_addr,
  input logic               hit_valid,
  input logic [NUM_WIN:0]   hit_vec,
  input logic [ADDR_W-1:0]  xlat_addr
);

  function automatic logic in_hole(input logic [ADDR_W-1:0] a);
    logic [EXT_W-1:0] x;
    x = {1'b0, a};
    return (x >= HOLE0_LO && x < HOLE0_HI) || (x >= HOLE1_LO && x < HOLE1_HI);
  endfunction

  // R8: at most one window reported
  p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R8: a miss passes the address through
  p_miss_pass_r8: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (hit_vec == '0) -> (xlat_addr == $past(lk_addr)));

  // R11: result valid one cycle after request
  p_valid_lat_r11: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> hit_valid);

  p_valid_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !hit_valid);

  p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !hit_valid |-> (hit_vec == '0));

  // R9: I/O window forwards only a port address
  p_io_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (hit_valid && hit_vec[IO_IDX]) |-> (xlat_addr[ADDR_W-1:IO_KEEP] == '0));

  // R7: no programmable window hits inside a reserved hole
  p_hole_r7: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (|hit_vec[NUM_WIN-1:0]) -> !in_hole($past(lk_addr)));

endmodule

bind awd_decoder awd_checker #(
  .NUM_WIN(NUM_WIN), .IO_IDX(IO_IDX), .IO_KEEP(IO_KEEP)
) u_awd_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
  .hit_valid(hit_valid), .hit_vec(hit_vec), .xlat_addr(xlat_addr)
);

// File: tb/test_awd_decoder.sv
module test_awd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int NW  = 4;
  localparam int RAW = 5;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [RAW-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic        hit_valid;
  logic [NW:0] hit_vec;
  logic [31:0] xlat_addr;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  awd_decoder i_awd_decoder (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .hit_valid(hit_valid),
    .hit_vec(hit_vec), .xlat_addr(xlat_addr)
  );

  // {addr, expected hit vector, expected translation}
  localparam logic [68:0] VEC [0:14] = '{
    {32'h013FFFFF, 5'b00000, 32'h013FFFFF},
    {32'h0140BEEF, 5'b00001, 32'h0000BEEF},
    {32'h015FFFFF, 5'b00001, 32'h0000FFFF},
    {32'h01600000, 5'b01000, 32'h01600000},
    {32'h017FFFFF, 5'b01000, 32'h017FFFFF},
    {32'h01800000, 5'b00000, 32'h01800000},
    {32'h1D123456, 5'b00010, 32'h00B23456},
    {32'h1DFFFFFF, 5'b00010, 32'h019FFFFF},
    {32'h1E000000, 5'b00000, 32'h1E000000},
    {32'h1EB00000, 5'b00000, 32'h1EB00000},
    {32'h1F100000, 5'b00100, 32'h1F100000},
    {32'h1F5FFFFF, 5'b00100, 32'h1F5FFFFF},
    {32'h1F600000, 5'b00000, 32'h1F600000},
    {32'h1BE00ABC, 5'b10000, 32'h00000ABC},
    {32'h1BE01000, 5'b00000, 32'h1BE01000}
  };

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [RAW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [RAW-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    chk32(tag, reg_rdata, exp);
  endtask

  task automatic look(input string tag, input logic [31:0] a,
                      input logic [NW:0] eh, input logic [31:0] ex);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk32({tag, " valid"}, 32'(hit_valid), 32'd1);
    chk32({tag, " hit"}, 32'(hit_vec), 32'(eh));
    chk32({tag, " xlat"}, xlat_addr, ex);
  endtask

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
    reg_wdata = '0; lk_valid = 1'b0; lk_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    chk32("R10 hit_valid", 32'(hit_valid), 32'd0);
    chk32("R10 hit_vec", 32'(hit_vec), 32'd0);
    rd("R10 low0", 5'd0, 32'h7F);
    rd("R10 high0", 5'd1, 32'h0);
    rd("R10 remap0", 5'd2, 32'h7F);
    rd("R10 ibase", 5'd16, 32'hDF);
    look("R10 R4 disabled", 32'h0FE00000, 5'b00000, 32'h0FE00000);
    look("R10 R6 iwin", 32'h1BE00004, 5'b10000, 32'h00000004);

    // program windows
    wr(5'd0, 32'h0000000A); wr(5'd1, 32'h0000000A); wr(5'd2, 32'h00000001);
    wr(5'd4, 32'h000000E8); wr(5'd5, 32'h0000007F); wr(5'd6, 32'h00001805);
    wr(5'd8, 32'hFFFF80F5); wr(5'd9, 32'h0000007A);
    wr(5'd12, 32'h0000000A); wr(5'd13, 32'h0000000B);

    rd("R1 low mask", 5'd8, 32'h000000F5);
    rd("R1 remap reload", 5'd10, 32'h000000F5);
    rd("R2 remap mask", 5'd6, 32'h00000005);
    rd("R1 field3 reads zero", 5'd11, 32'h0);

    // table walk: R3 R5 R6 R7 R8 R9
    for (int i = 0; i < 15; i++) begin
      look($sformatf("R3/R5/R7/R8/R9 vec%0d", i),
           VEC[i][68:37], VEC[i][36:32], VEC[i][31:0]);
    end

    // R11: write and lookup in the same cycle see the old state
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'd13; reg_wdata = 32'hFFFFFF85;
    lk_valid = 1'b1; lk_addr = 32'h01700000;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    lk_valid = 1'b1; lk_addr = 32'h01700000;
    chk32("R11 same-cycle old hit", 32'(hit_vec), 32'b01000);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk32("R11 R4 next-cycle miss", 32'(hit_vec), 32'b00000);
    chk32("R8 miss passthrough", xlat_addr, 32'h01700000);
    @(negedge clk);
    chk32("R11 idle valid", 32'(hit_valid), 32'd0);
    rd("R2 high mask", 5'd13, 32'h00000005);

    // R6 relocate internal window
    wr(5'd16, 32'hFFFF8010);
    rd("R6 ibase mask", 5'd16, 32'h00000010);
    look("R6 iwin new", 32'h02000004, 5'b10000, 32'h00000004);
    look("R6 iwin old gone", 32'h1BE00ABC, 5'b00000, 32'h1BE00ABC);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule